// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a memory-mapped interval timer. An up-counter advances on a count tick that a prescaler derives from a slow base tick. Four divide ratios are selectable. The counter is compared against a compare register. When the counter equals the compare value on a count tick, the channel sets a sticky match flag. In periodic mode the counter then restarts from zero. In free-running mode it keeps counting and sets a sticky overflow flag when it wraps from all ones to zero.

Software reaches the channel through a simple word-indexed register port:

| Index | Register |
|-------|----------|
| 0 | control/status |
| 1 | counter |
| 2 | compare |
| 3 | start/stop |

Reads are combinational from the index. Writes are captured on the clock edge while the write strobe is high. The start/stop register is wider than one channel needs. This channel owns one bit of it, placed by a parameter, and keeps the other bits as plain storage. A value written to the counter is held back and lands only after two base ticks.

The match flag drives two level-sensitive request outputs. One is an interrupt line. The other is a stub DMA request line.

Top module: `match_timer`

## Requirements
- R1: After reset, the control/status, counter and start/stop registers read 0, the compare register reads all ones, and both request outputs are low.
- R2: Control/status layout: bit 15 is the match flag, bit 14 is the overflow flag, bit 8 selects the mode (1 free-running, 0 periodic), bit 7 enables the interrupt, bits 5:4 are the request type and bits 2:0 are the clock select. All other bits read 0. The compare register at index 2 reads back what was written.
- R3: The clock select codes give these divide ratios of the base tick: 7 gives 1, 4 gives 8, 5 gives 32 and 6 gives 128. With the base tick high every cycle, the first match after start comes (compare+1)·ratio cycles after the start write.
- R4: Clock select codes 0 to 3 give no count tick, so the counter holds while the channel runs.
- R5: In periodic mode the match flag sets on the count tick where counter equals compare, and the counter goes to 0. Successive matches are therefore (compare+1)·ratio cycles apart.
- R6: Writing 0 to the match or overflow flag clears it. Writing 1 to either flag leaves it unchanged.
- R7: In free-running mode the counter passes the compare value without restarting. The match flag still sets at the compare value, and the overflow flag sets on the tick that wraps the counter from all ones to 0.
- R8: The channel counts only while bit RUN_BIT (default 3) of the start/stop register at index 3 is 1. The other bits of that register are stored and read back unchanged.
- R9: A counter write becomes visible to reads, and takes effect, on the second base tick after the write edge. The reads in between return the old value.
- R10: The interrupt output is high exactly while the match flag is set, the interrupt enable is set and the request type is 2. The DMA request is high while the match flag is set and the request type is 1.
- R11: Writing 0 to the control/status register drops both request outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Slow-clock enable pulse that feeds the prescaler and the counter-write delay |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data for reg_idx |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | Level DMA request (stub) |

## Verification
The period is measured for every divider code, each with a different compare value. An error in the divide ratio or an off-by-one in the compare-plus-one period gives a different rise cycle for each code. Each code is timed over two consecutive matches. That separates a correct restart-from-zero from a counter that runs on past the compare value.

The free-running case starts the counter just below all ones. This shows that the overflow flag sets before the match flag and independently of it. A run with request type 1 and the enable set shows that the two request outputs are selected by type alone. The counter-write latency test steps the base tick by hand. It separates a one-tick delay from the required two-tick delay.

// File: rtl/match_timer_pkg.sv
`timescale 1ns/1ps
package match_timer_pkg;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DMA  = 2'd1,
        REQ_IRQ  = 2'd2,
        REQ_RSVD = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic      free_run;
        logic      irq_en;
        req_kind_e req;
        logic [2:0] clk_sel;
    } ctrl_cfg_t;

    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_COUNT = 1;
    localparam int unsigned IDX_CMP   = 2;
    localparam int unsigned IDX_RUN   = 3;

    localparam int unsigned BIT_CMF  = 15;
    localparam int unsigned BIT_OVF  = 14;
    localparam int unsigned BIT_MODE = 8;
    localparam int unsigned BIT_IE   = 7;

    localparam int unsigned MAX_RATIO = 128;
    localparam int unsigned PRE_W     = $clog2(MAX_RATIO);

    // Divide ratio for a clock-select code; 0 means no count tick.
    function automatic int unsigned div_ratio(input logic [2:0] code);
        case (code)
            3'd4:    return 8;
            3'd5:    return 32;
            3'd6:    return 128;
            3'd7:    return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] pack_ctrl(input ctrl_cfg_t c, input logic cmf,
                                              input logic ovf);
        logic [15:0] r;
        r           = '0;
        r[BIT_CMF]  = cmf;
        r[BIT_OVF]  = ovf;
        r[BIT_MODE] = c.free_run;
        r[BIT_IE]   = c.irq_en;
        r[5:4]      = c.req;
        r[2:0]      = c.clk_sel;
        return r;
    endfunction

    function automatic ctrl_cfg_t unpack_ctrl(input logic [15:0] w);
        ctrl_cfg_t c;
        c.free_run = w[BIT_MODE];
        c.irq_en   = w[BIT_IE];
        c.req      = req_kind_e'(w[5:4]);
        c.clk_sel  = w[2:0];
        return c;
    endfunction

endpackage

// File: rtl/match_timer_prescale.sv
`timescale 1ns/1ps
module match_timer_prescale
    import match_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       run,
    input  logic [2:0] clk_sel,
    output logic       cnt_tick
);

    int unsigned      ratio;
    logic             sel_valid;
    logic [PRE_W-1:0] last;
    logic [PRE_W-1:0] pcnt_q;

    always_comb begin
        ratio     = div_ratio(clk_sel);
        sel_valid = (ratio != 0);
        last      = sel_valid ? PRE_W'(ratio - 1) : '0;
    end

    assign cnt_tick = run && sel_valid && base_tick && (pcnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !run || !sel_valid) begin
            pcnt_q <= '0;
        end else if (base_tick) begin
            pcnt_q <= (pcnt_q >= last) ? '0 : pcnt_q + 1'b1;
        end
    end

    // R3: a divided tick is never followed at once by another one
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && clk_sel != 3'd7) |=> (!cnt_tick || clk_sel == 3'd7));

endmodule

// File: rtl/match_timer_core.sv
`timescale 1ns/1ps
module match_timer_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_tick,
    input  logic             cnt_tick,
    input  logic             free_run,
    input  logic [CNT_W-1:0] cmp,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             clr_cmf,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] count_q,
    output logic             cmf_q,
    output logic             ovf_q
);

    logic             pend_q;
    logic             wait_q;
    logic [CNT_W-1:0] pend_val_q;
    logic             load_now;
    logic             adv;
    logic             hit;
    logic             at_top;

    assign load_now = pend_q && wait_q && base_tick && !cnt_wr;
    assign adv      = cnt_tick && !load_now;
    assign hit      = (count_q == cmp);
    assign at_top   = &count_q;

    // Delayed counter write: armed by the write, lands on the second base tick
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            wait_q     <= 1'b0;
            pend_val_q <= '0;
        end else if (cnt_wr) begin
            pend_q     <= 1'b1;
            wait_q     <= 1'b0;
            pend_val_q <= cnt_wdata;
        end else if (pend_q && base_tick) begin
            if (wait_q) begin
                pend_q <= 1'b0;
                wait_q <= 1'b0;
            end else begin
                wait_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_now) begin
            count_q <= pend_val_q;
        end else if (adv) begin
            count_q <= (hit && !free_run) ? '0 : count_q + 1'b1;
        end
    end

    // Sticky flags: hardware set has priority over a software clear
    always_ff @(posedge clk) begin
        if (rst) begin
            cmf_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (adv && hit)                  cmf_q <= 1'b1;
            else if (clr_cmf)                cmf_q <= 1'b0;
            if (adv && free_run && at_top)   ovf_q <= 1'b1;
            else if (clr_ovf)                ovf_q <= 1'b0;
        end
    end

    // R5: periodic match restarts the counter from zero
    a_r5_periodic_restart: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && !pend_q && !free_run && count_q == cmp) |=> (count_q == '0));

    // R6: a set match flag stays set unless software clears it
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (cmf_q && !clr_cmf) |=> cmf_q);

    // R7: overflow only rises out of an all-ones counter in free-running mode
    a_r7_ovf_from_top: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> ($past(free_run) && (&$past(count_q))));

    // R9: with no tick and no pending write the counter cannot move
    a_r9_no_early_load: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick && !pend_q) |=> $stable(count_q));

endmodule

// File: rtl/match_timer_regs.sv
`timescale 1ns/1ps
module match_timer_regs
    import match_timer_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned SS_W    = 8,
    parameter int unsigned RUN_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              cmf,
    input  logic              ovf,
    output ctrl_cfg_t         cfg,
    output logic [CNT_W-1:0]  cmp,
    output logic              run,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              clr_cmf,
    output logic              clr_ovf,
    output logic [DATA_W-1:0] rdata
);

    logic [SS_W-1:0] ss_q;
    logic            wr_ctrl;
    logic            wr_cmp;
    logic            wr_ss;

    assign wr_ctrl   = wr_en && (idx == 2'(IDX_CTRL));
    assign wr_cmp    = wr_en && (idx == 2'(IDX_CMP));
    assign wr_ss     = wr_en && (idx == 2'(IDX_RUN));
    assign cnt_wr    = wr_en && (idx == 2'(IDX_COUNT));
    assign cnt_wdata = wdata[CNT_W-1:0];
    assign clr_cmf   = wr_ctrl && !wdata[BIT_CMF];
    assign clr_ovf   = wr_ctrl && !wdata[BIT_OVF];
    assign run       = ss_q[RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            cmp  <= '1;
            ss_q <= '0;
        end else begin
            if (wr_ctrl) cfg  <= unpack_ctrl(wdata[15:0]);
            if (wr_cmp)  cmp  <= wdata[CNT_W-1:0];
            if (wr_ss)   ss_q <= wdata[SS_W-1:0];
        end
    end

    always_comb begin
        case (idx)
            2'(IDX_CTRL):  rdata = DATA_W'(pack_ctrl(cfg, cmf, ovf));
            2'(IDX_COUNT): rdata = DATA_W'(count);
            2'(IDX_CMP):   rdata = DATA_W'(cmp);
            default:       rdata = DATA_W'(ss_q);
        endcase
    end

endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
    import match_timer_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned SS_W    = 8,
    parameter int unsigned RUN_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              reg_wr,
    input  logic [1:0]        reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              dma_req
);

    ctrl_cfg_t        cfg;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cnt_wdata;
    logic             run;
    logic             cnt_wr;
    logic             clr_cmf;
    logic             clr_ovf;
    logic             cmf;
    logic             ovf;
    logic             cnt_tick;

    match_timer_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SS_W   (SS_W),
        .RUN_BIT(RUN_BIT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .idx      (reg_idx),
        .wdata    (reg_wdata),
        .count    (count),
        .cmf      (cmf),
        .ovf      (ovf),
        .cfg      (cfg),
        .cmp      (cmp),
        .run      (run),
        .cnt_wr   (cnt_wr),
        .cnt_wdata(cnt_wdata),
        .clr_cmf  (clr_cmf),
        .clr_ovf  (clr_ovf),
        .rdata    (reg_rdata)
    );

    match_timer_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .base_tick(base_tick),
        .run      (run),
        .clk_sel  (cfg.clk_sel),
        .cnt_tick (cnt_tick)
    );

    match_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .base_tick(base_tick),
        .cnt_tick (cnt_tick),
        .free_run (cfg.free_run),
        .cmp      (cmp),
        .cnt_wr   (cnt_wr),
        .cnt_wdata(cnt_wdata),
        .clr_cmf  (clr_cmf),
        .clr_ovf  (clr_ovf),
        .count_q  (count),
        .cmf_q    (cmf),
        .ovf_q    (ovf)
    );

    assign irq     = cmf && cfg.irq_en && (cfg.req == REQ_IRQ);
    assign dma_req = cmf && (cfg.req == REQ_DMA);

    // R10: the interrupt never rises while its type is not selected
    a_r10_irq_type: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cfg.req == REQ_IRQ && cfg.irq_en));

    // R11: a zero control write leaves no request pending afterwards
    a_r11_zero_ctrl: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_idx == 2'(IDX_CTRL) && reg_wdata[15:0] == 16'h0
         && !cnt_tick) |=> (!irq && !dma_req));

endmodule

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;

    localparam int unsigned RUN_BIT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        dma_req;

    int unsigned nchk = 0;
    int unsigned nerr = 0;
    int unsigned cyc  = 0;
    int unsigned exp_q[$];
    logic        irq_prev = 1'b0;
    logic        done = 1'b0;

    match_timer #(.RUN_BIT(RUN_BIT)) i_match_timer (
        .clk      (clk),
        .rst      (rst),
        .base_tick(base_tick),
        .reg_wr   (reg_wr),
        .reg_idx  (reg_idx),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq),
        .dma_req  (dma_req)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: pops the expected cycle of every interrupt rise
    always @(posedge clk) begin
        #1;
        if (!rst && irq && !irq_prev) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected irq rise", cyc, 32'hFFFF_FFFF);
            end else begin
                chk("R3/R5 irq rise cycle", cyc, exp_q.pop_front());
            end
        end
        irq_prev = irq;
    end

    task automatic wr(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] data);
        @(negedge clk);
        reg_idx = idx;
        #1 data = reg_rdata;
    endtask

    task automatic tick_pulse();
        @(negedge clk); base_tick = 1'b1;
        @(negedge clk); base_tick = 1'b0;
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (!irq) @(negedge clk);
    endtask

    task automatic period_run(input logic [2:0] code, input int unsigned ratio,
                              input int unsigned cmpv);
        int unsigned t0;
        logic [31:0] ctrl;
        ctrl = 32'h00A0 | 32'(code);          // irq enable, request type 2, periodic
        wr(2'd0, ctrl);
        wr(2'd2, cmpv);
        wr(2'd1, 32'd0);
        repeat (4) @(negedge clk);
        wr(2'd3, 32'(1) << RUN_BIT);
        t0 = cyc;
        exp_q.push_back(t0 + (cmpv + 1) * ratio);
        exp_q.push_back(t0 + 2 * (cmpv + 1) * ratio);
        wait_irq();
        chk("R10 no dma with irq type", {31'd0, dma_req}, 32'd0);
        wr(2'd0, ctrl);                       // bit 15 zero clears the flag
        chk("R6 clear drops irq", {31'd0, irq}, 32'd0);
        wait_irq();
        wr(2'd3, 32'd0);
        wr(2'd0, 32'd0);
        chk("R11 zero ctrl drops irq", {31'd0, irq}, 32'd0);
        chk("R11 zero ctrl drops dma", {31'd0, dma_req}, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] old;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl reset", v, 32'h0);
        rd(2'd1, v); chk("R1 count reset", v, 32'h0);
        rd(2'd2, v); chk("R1 compare reset", v, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R1 start/stop reset", v, 32'h0);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
        chk("R1 dma reset", {31'd0, dma_req}, 32'd0);

        // R2 layout
        wr(2'd0, 32'h0000_FFFF);
        rd(2'd0, v); chk("R2 ctrl implemented bits", v, 32'h0000_01B7);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, v); chk("R2 compare readback", v, 32'h1234_5678);
        wr(2'd0, 32'h0);

        // R8 peer bits stored, run bit clear keeps counter still
        wr(2'd0, 32'h0000_0007);
        wr(2'd3, 32'h0000_00A5);
        rd(2'd3, v); chk("R8 start/stop readback", v, 32'h0000_00A5);
        repeat (10) @(negedge clk);
        rd(2'd1, v); chk("R8 no count when run bit clear", v, 32'h0);
        wr(2'd3, 32'h0);

        // R4 codes 0..3 give no count
        wr(2'd0, 32'h0000_0002);
        wr(2'd3, 32'(1) << RUN_BIT);
        repeat (10) @(negedge clk);
        rd(2'd1, v); chk("R4 code 2 holds counter", v, 32'h0);
        wr(2'd3, 32'h0);

        // R3 / R5 / R10 per divider code
        period_run(3'd7, 1, 9);
        period_run(3'd4, 8, 4);
        period_run(3'd5, 32, 2);
        period_run(3'd6, 128, 1);

        // R9 counter write latency
        base_tick = 1'b0;
        rd(2'd1, old);
        wr(2'd1, 32'h0000_0055);
        rd(2'd1, v); chk("R9 old value right after write", v, old);
        tick_pulse();
        rd(2'd1, v); chk("R9 old value after one tick", v, old);
        tick_pulse();
        rd(2'd1, v); chk("R9 new value after two ticks", v, 32'h0000_0055);
        base_tick = 1'b1;

        // R7 free-running with overflow
        wr(2'd0, 32'h0000_0107);
        wr(2'd2, 32'h0000_0010);
        wr(2'd1, 32'hFFFF_FFFD);
        repeat (4) @(negedge clk);
        wr(2'd3, 32'(1) << RUN_BIT);
        repeat (8) @(negedge clk);
        rd(2'd0, v); chk("R7 overflow set, match not yet", v, 32'h0000_4107);
        repeat (30) @(negedge clk);
        rd(2'd0, v); chk("R7 match set in free-running", v, 32'h0000_C107);
        wr(2'd3, 32'h0);
        rd(2'd1, v);
        chk("R7 counter passed compare", {31'd0, (v > 32'h10 && v < 32'h100)}, 32'd1);
        chk("R10 no irq with enable off", {31'd0, irq}, 32'd0);

        // R6 write-one keeps, write-zero clears
        wr(2'd0, 32'h0000_C107);
        rd(2'd0, v); chk("R6 writing ones keeps flags", v, 32'h0000_C107);
        wr(2'd0, 32'h0000_8107);
        rd(2'd0, v); chk("R6 zero clears overflow only", v, 32'h0000_8107);
        wr(2'd0, 32'h0000_4107);
        rd(2'd0, v); chk("R6 zero clears match", v, 32'h0000_0107);

        // R10 / R11 DMA request type
        wr(2'd0, 32'h0000_0097);
        wr(2'd2, 32'd3);
        wr(2'd1, 32'd0);
        repeat (4) @(negedge clk);
        wr(2'd3, 32'(1) << RUN_BIT);
        repeat (10) @(negedge clk);
        chk("R10 dma with type 1", {31'd0, dma_req}, 32'd1);
        chk("R10 no irq with type 1", {31'd0, irq}, 32'd0);
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h0);
        chk("R11 zero ctrl drops dma", {31'd0, dma_req}, 32'd0);
        rd(2'd0, v); chk("R11 ctrl reads zero", v, 32'h0);

        repeat (2) @(negedge clk);
        chk("R3 all expected rises seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule